// File: doc/BRIEF.md
# Pipelined Minimum-Key Selector

This block looks at a wide parallel set of integer keys, each carrying a one-bit payload, and reports which key is the smallest. The default build takes 256 keys. It returns that key's payload, the key value itself and the position of the winning input. A new complete set of keys can be presented on every clock, and one answer comes out per clock after a fixed pipeline delay.

Internally the keys pass through a binary tree of two-input compare-and-select cells. Every tree level ends in a register stage. Each cell passes on the smaller key together with its payload and its position, so the next level compares keys again and never compares payloads. A valid flag travels beside the data so that the consumer knows which output cycles carry a real result. The key comparison is unsigned by default. A parameter switches it to two's-complement.

Top module: `argmin_tree`

## Requirements
- R1: Parameters set the key count N (a power of two, at least 2) and the key width W. The tree has LEVELS = log2(N) stages. A new key set is accepted on every clock, and every accepted set yields its own result.
- R2: A key set sampled at a rising edge with `in_vld` high appears on the outputs exactly LEVELS rising edges later, with `out_vld` high.
- R3: `out_key` equals the smallest of the N keys. Key i occupies bits [i*W +: W] of `in_key`.
- R4: `out_pay` equals bit i of `in_pay`, where i is the winning input.
- R5: `out_idx` is the binary position (0 to N-1) of the winning input.
- R6: Each cell uses a strict less-than test, so on equal keys the higher-indexed side of the pair wins. Among several equal smallest keys, the highest-indexed one is therefore reported.
- R7: With SIGNED=0 the keys are compared as unsigned numbers, so an all-ones key is the largest value.
- R8: With SIGNED=1 the keys are compared as two's-complement numbers, so an all-ones key (-1) is smaller than zero.
- R9: While the active-high asynchronous reset `rst` is asserted, `out_pay`, `out_key`, `out_idx` and `out_vld` are all 0, with no clock edge needed.
- R10: A cycle with `in_vld` low produces `out_vld` low LEVELS edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| in_vld | input | 1 | The key set on this cycle is valid |
| in_key | input | N*W | Packed keys; key i at bits [i*W +: W] |
| in_pay | input | N | Payload bit for each key |
| out_vld | output | 1 | The outputs carry a result |
| out_key | output | W | Smallest key |
| out_pay | output | 1 | Payload of the smallest key |
| out_idx | output | LEVELS | Position of the smallest key |

## Verification
The checker keeps its own LEVELS-deep record of the applied key and payload sets. It compares the outputs against that record only when the delayed valid flag says the record is full of data sampled after reset. The checker therefore assumes that the keys and payloads are known (not X) on every cycle in which `in_vld` is high. The stimulus always drives defined values on every input from time zero. The vector table contains equal-key cases, both within a pair and across the tree, as well as all-ones keys, so that the tie rule and the signedness rule are exercised.

// File: rtl/argmin_pkg.sv
package argmin_pkg;

    // Number of tree levels for a power-of-two input count.
    function automatic int unsigned tree_levels(input int unsigned n);
        return $clog2(n);
    endfunction

endpackage

// File: rtl/argmin_cell.sv
// Two-input compare-and-select: passes on key, payload and position of the
// smaller key; on a tie or when b is smaller, side b (higher index) wins.
module argmin_cell #(
    parameter int W      = 8,
    parameter int IW     = 8,
    parameter int LVL    = 0,
    parameter bit SIGNED = 1'b0
) (
    input  logic [W-1:0]  key_a,
    input  logic [W-1:0]  key_b,
    input  logic          pay_a,
    input  logic          pay_b,
    input  logic [IW-1:0] idx_a,
    input  logic [IW-1:0] idx_b,
    output logic [W-1:0]  key_o,
    output logic          pay_o,
    output logic [IW-1:0] idx_o
);
    logic a_lt_b;
    logic take_b;

    generate
        if (SIGNED) begin : g_sgn
            always_comb a_lt_b = ($signed(key_a) < $signed(key_b));
        end else begin : g_uns
            always_comb a_lt_b = (key_a < key_b);
        end
    endgenerate

    always_comb begin
        take_b     = ~a_lt_b;
        key_o      = take_b ? key_b : key_a;
        pay_o      = take_b ? pay_b : pay_a;
        idx_o      = take_b ? idx_b : idx_a;
        idx_o[LVL] = take_b;
    end
endmodule

// File: rtl/argmin_level.sv
// One tree level: NI/2 compare cells followed by one register stage.
module argmin_level #(
    parameter int W      = 8,
    parameter int NI     = 4,
    parameter int IW     = 2,
    parameter int LVL    = 0,
    parameter bit SIGNED = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic [NI*W-1:0]        in_key,
    input  logic [NI-1:0]          in_pay,
    input  logic [NI*IW-1:0]       in_idx,
    output logic                   out_vld,
    output logic [(NI/2)*W-1:0]    out_key,
    output logic [(NI/2)-1:0]      out_pay,
    output logic [(NI/2)*IW-1:0]   out_idx
);
    localparam int NO = NI / 2;

    typedef struct packed {
        logic               vld;
        logic [NO*W-1:0]    key;
        logic [NO-1:0]      pay;
        logic [NO*IW-1:0]   idx;
    } stage_t;

    stage_t st_d, st_q;

    logic [NO*W-1:0]  win_key;
    logic [NO-1:0]    win_pay;
    logic [NO*IW-1:0] win_idx;

    for (genvar j = 0; j < NO; j++) begin : g_cell
        argmin_cell #(
            .W(W), .IW(IW), .LVL(LVL), .SIGNED(SIGNED)
        ) i_cell (
            .key_a (in_key[(2*j)*W +: W]),
            .key_b (in_key[(2*j+1)*W +: W]),
            .pay_a (in_pay[2*j]),
            .pay_b (in_pay[2*j+1]),
            .idx_a (in_idx[(2*j)*IW +: IW]),
            .idx_b (in_idx[(2*j+1)*IW +: IW]),
            .key_o (win_key[j*W +: W]),
            .pay_o (win_pay[j]),
            .idx_o (win_idx[j*IW +: IW])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        st_d.key = win_key;
        st_d.pay = win_pay;
        st_d.idx = win_idx;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_key = st_q.key;
    assign out_pay = st_q.pay;
    assign out_idx = st_q.idx;
endmodule

// File: rtl/argmin_tree.sv
module argmin_tree #(
    parameter int N      = 256,
    parameter int W      = 8,
    parameter bit SIGNED = 1'b0,
    parameter int LEVELS = argmin_pkg::tree_levels(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [N*W-1:0]    in_key,
    input  logic [N-1:0]      in_pay,
    output logic              out_vld,
    output logic [W-1:0]      out_key,
    output logic              out_pay,
    output logic [LEVELS-1:0] out_idx
);
    localparam int IW = LEVELS;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int NI = N >> l;
        localparam int NO = NI / 2;

        logic               v_in;
        logic [NI*W-1:0]    k_in;
        logic [NI-1:0]      p_in;
        logic [NI*IW-1:0]   x_in;
        logic               v_out;
        logic [NO*W-1:0]    k_out;
        logic [NO-1:0]      p_out;
        logic [NO*IW-1:0]   x_out;

        if (l == 0) begin : g_first
            assign v_in = in_vld;
            assign k_in = in_key;
            assign p_in = in_pay;
            assign x_in = '0;
        end else begin : g_next
            assign v_in = g_lvl[l-1].v_out;
            assign k_in = g_lvl[l-1].k_out;
            assign p_in = g_lvl[l-1].p_out;
            assign x_in = g_lvl[l-1].x_out;
        end

        argmin_level #(
            .W(W), .NI(NI), .IW(IW), .LVL(l), .SIGNED(SIGNED)
        ) i_level (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (v_in),
            .in_key  (k_in),
            .in_pay  (p_in),
            .in_idx  (x_in),
            .out_vld (v_out),
            .out_key (k_out),
            .out_pay (p_out),
            .out_idx (x_out)
        );
    end

    assign out_vld = g_lvl[LEVELS-1].v_out;
    assign out_key = g_lvl[LEVELS-1].k_out;
    assign out_pay = g_lvl[LEVELS-1].p_out;
    assign out_idx = g_lvl[LEVELS-1].x_out;
endmodule

// File: rtl/argmin_tree_chk.sv
module argmin_tree_chk #(
    parameter int N      = 256,
    parameter int W      = 8,
    parameter bit SIGNED = 1'b0,
    parameter int LEVELS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [N*W-1:0]    in_key,
    input logic [N-1:0]      in_pay,
    input logic              out_vld,
    input logic [W-1:0]      out_key,
    input logic              out_pay,
    input logic [LEVELS-1:0] out_idx
);
    logic [N*W-1:0]    hist_key [LEVELS];
    logic [N-1:0]      hist_pay [LEVELS];
    logic [LEVELS-1:0] hist_vld;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hist_vld <= '0;
        end else begin
            hist_vld <= {hist_vld[LEVELS-2:0], in_vld};
        end
    end

    always_ff @(posedge clk) begin
        hist_key[0] <= in_key;
        hist_pay[0] <= in_pay;
        for (int s = 1; s < LEVELS; s++) begin
            hist_key[s] <= hist_key[s-1];
            hist_pay[s] <= hist_pay[s-1];
        end
    end

    logic [W-1:0]      ref_key;
    logic [W-1:0]      cand;
    logic [LEVELS-1:0] ref_idx;
    logic              ref_pay;
    logic              cand_lt;

    always_comb begin
        ref_key = hist_key[LEVELS-1][W-1:0];
        ref_idx = '0;
        cand    = '0;
        cand_lt = 1'b0;
        for (int i = 1; i < N; i++) begin
            cand    = hist_key[LEVELS-1][i*W +: W];
            cand_lt = SIGNED ? ($signed(ref_key) < $signed(cand)) : (ref_key < cand);
            if (!cand_lt) begin
                ref_key = cand;
                ref_idx = LEVELS'(i);
            end
        end
        ref_pay = hist_pay[LEVELS-1][ref_idx];
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |-> (!out_vld && out_pay == 1'b0 && out_key == '0 && out_idx == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld == hist_vld[LEVELS-1]);

    // R3
    min_key_chk: assert property (@(posedge clk) disable iff (rst)
        hist_vld[LEVELS-1] |-> out_key == ref_key);

    // R5
    win_index_chk: assert property (@(posedge clk) disable iff (rst)
        hist_vld[LEVELS-1] |-> out_idx == ref_idx);

    // R4
    payload_chk: assert property (@(posedge clk) disable iff (rst)
        hist_vld[LEVELS-1] |-> out_pay == ref_pay);
endmodule

bind argmin_tree argmin_tree_chk #(
    .N(N), .W(W), .SIGNED(SIGNED), .LEVELS(LEVELS)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_key  (in_key),
    .in_pay  (in_pay),
    .out_vld (out_vld),
    .out_key (out_key),
    .out_pay (out_pay),
    .out_idx (out_idx)
);

// File: tb/test_argmin_tree.sv
module test_argmin_tree;
    localparam int N  = 8;
    localparam int W  = 4;
    localparam int LV = 3;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          in_vld = 1'b0;
    logic [N*W-1:0] in_key = '0;
    logic [N-1:0]  in_pay = '0;
    logic          out_vld;
    logic [W-1:0]  out_key;
    logic          out_pay;
    logic [LV-1:0] out_idx;

    argmin_tree #(.N(N), .W(W)) i_argmin_tree (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_key(in_key), .in_pay(in_pay),
        .out_vld(out_vld), .out_key(out_key), .out_pay(out_pay), .out_idx(out_idx)
    );

    logic        s_vld = 1'b0;
    logic [15:0] s_key = '0;
    logic [3:0]  s_pay = '0;
    logic        s_ovld;
    logic [3:0]  s_okey;
    logic        s_opay;
    logic [1:0]  s_oidx;

    argmin_tree #(.N(4), .W(4), .SIGNED(1'b1)) i_argmin_tree_sgn (
        .clk(clk), .rst(rst), .in_vld(s_vld), .in_key(s_key), .in_pay(s_pay),
        .out_vld(s_ovld), .out_key(s_okey), .out_pay(s_opay), .out_idx(s_oidx)
    );

    typedef struct packed {
        logic [31:0] k;
        logic [7:0]  p;
        logic [3:0]  ek;
        logic        ep;
        logic [2:0]  ei;
    } vec_t;

    // key i is nibble i counted from the right
    localparam vec_t VT [NV] = '{
        '{32'h7654_3210, 8'h01, 4'h0, 1'b1, 3'd0},
        '{32'h0123_4567, 8'h7F, 4'h0, 1'b0, 3'd7},
        '{32'h9A3B_C5D8, 8'h20, 4'h3, 1'b1, 3'd5},
        '{32'h5555_5555, 8'h80, 4'h5, 1'b1, 3'd7},
        '{32'h9299_9929, 8'h02, 4'h2, 1'b0, 3'd6},
        '{32'h1111_111F, 8'h01, 4'h1, 1'b0, 3'd7},
        '{32'h8888_0088, 8'h04, 4'h0, 1'b0, 3'd3},
        '{32'hEDC1_BA98, 8'h10, 4'h1, 1'b1, 3'd4}
    };
    localparam string VR [NV] = '{"R3", "R3", "R3", "R6", "R6", "R7", "R6", "R3"};

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9: outputs are clear while reset is held
        repeat (2) @(negedge clk);
        check("R9", {28'd0, out_vld, out_pay}, 32'd0);
        check("R9", {25'd0, out_idx, out_key}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R3 R4 R5 R6 R7: back-to-back stream, one result per vector
        for (int k = 0; k < NV + LV; k++) begin
            if (k >= LV) begin
                check("R1", {31'd0, out_vld}, 32'd1);
                check("R3", {28'd0, out_key}, {28'd0, VT[k-LV].ek});
                check("R4", {31'd0, out_pay}, {31'd0, VT[k-LV].ep});
                check(VR[k-LV], {29'd0, out_idx}, {29'd0, VT[k-LV].ei});
            end
            if (k < NV) begin
                in_vld = 1'b1;
                in_key = VT[k].k;
                in_pay = VT[k].p;
            end else begin
                in_vld = 1'b0;
            end
            @(negedge clk);
        end

        // R10: invalid cycles give invalid outputs
        repeat (LV) @(negedge clk);
        check("R10", {31'd0, out_vld}, 32'd0);

        // R2: a single valid set appears exactly LV edges later
        in_vld = 1'b1;
        in_key = VT[2].k;
        in_pay = VT[2].p;
        @(negedge clk);
        in_vld = 1'b0;
        check("R2", {31'd0, out_vld}, 32'd0);
        @(negedge clk);
        check("R2", {31'd0, out_vld}, 32'd0);
        @(negedge clk);
        check("R2", {31'd0, out_vld}, 32'd1);
        check("R2", {28'd0, out_key}, 32'h3);
        @(negedge clk);
        check("R2", {31'd0, out_vld}, 32'd0);

        // R8: signed comparison, all-ones key is -1
        s_vld = 1'b1;
        s_key = 16'h0F70;
        s_pay = 4'b0100;
        @(negedge clk);
        s_key = 16'h8F00;
        s_pay = 4'b0111;
        @(negedge clk);
        s_vld = 1'b0;
        check("R8", {31'd0, s_ovld}, 32'd1);
        check("R8", {28'd0, s_okey}, 32'hF);
        check("R8", {30'd0, s_oidx}, 32'd2);
        check("R8", {31'd0, s_opay}, 32'd1);
        @(negedge clk);
        check("R8", {28'd0, s_okey}, 32'h8);
        check("R8", {30'd0, s_oidx}, 32'd3);
        check("R8", {31'd0, s_opay}, 32'd0);

        // R9: asynchronous reset clears outputs without a clock edge
        in_vld = 1'b1;
        in_key = VT[0].k;
        in_pay = VT[0].p;
        repeat (LV) @(negedge clk);
        check("R9", {31'd0, out_pay}, 32'd1);
        #1 rst = 1'b1;
        #1;
        check("R9", {31'd0, out_vld}, 32'd0);
        check("R9", {31'd0, out_pay}, 32'd0);
        check("R9", {25'd0, out_idx, out_key}, 32'd0);
        in_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule